// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block sits beside the core of a small 8-bit processor. It takes over the memory bus whenever an interrupt must be entered. It holds the pending requests: a reset request, a non-maskable request latched on a rising line, and two level-sensitive maskable sources. On each instruction-boundary strobe, and only while it is idle, it picks the most urgent request and runs the matching entry sequence.

For a non-maskable or maskable entry the block does the following, in order:
- It writes the return address, high byte first, then the low byte, into the stack page.
- It writes a packed copy of the processor flags into the stack page.
- It reads the 16-bit handler address from a fixed vector location, low byte first.
- It presents the new program counter, the new stack pointer and a disable-flag set strobe together with a one-cycle done pulse.

A reset entry skips the stack writes and only fetches its vector. The core keeps the program counter, stack pointer and flags. It feeds them in and applies the results when `done` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: When several requests are pending at an accepted boundary, reset wins over the non-maskable request, and the non-maskable request wins over the maskable sources.
- R2: A maskable entry starts only when at least one `irq_src` bit is high and the disable flag `cpu_flags[2]` is 0. With the flag at 1, a boundary causes no bus activity and no `done`.
- R3: The non-maskable request is latched on a 0-to-1 change of `nmi_line` and cleared when it is serviced. A line held high after service raises no second entry.
- R4: An interrupt entry writes three bytes to address `{8'h01, sp}`: PC[15:8] at `sp_in`, PC[7:0] at `sp_in-1`, the status byte at `sp_in-2`. The stack pointer wraps within 8 bits.
- R5: `cpu_flags` is ordered {N,V,D,I,Z,C} from bit 5 down to bit 0. The pushed status byte is {N,V,1,0,D,I,Z,C} from bit 7 down to bit 0.
- R6: The handler address is read low byte first from 16'hFFFC/FFFD for reset, 16'hFFFA/FFFB for the non-maskable request and 16'hFFFE/FFFF for the maskable one.
- R7: Take the clock edge that samples the accepting boundary as edge 0. For an interrupt entry, the three writes appear in cycles 2, 3 and 4 after that edge, and `done` is high for one cycle in cycle 7. `set_idis` is high with `done`, after the status write.
- R8: A reset entry writes nothing, raises `done` in cycle 4 with `set_idis` low and `sp_out` equal to `sp_in`, and discards any pending non-maskable request.
- R9: Requests are sampled only when `boundary` is high while the block is idle. A boundary during a sequence, or with nothing pending, has no effect.
- R10: With `done`, `pc_out` holds the fetched vector and `sp_out` holds `sp_in-3` for an interrupt entry. `kind_out` is 00 for reset, 01 for non-maskable and 10 for maskable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe |
| reset_req | input | 1 | One-cycle reset request pulse |
| nmi_line | input | 1 | Non-maskable request line |
| irq_src | input | 2 | Level-sensitive maskable sources |
| cpu_flags | input | 6 | Flags {N,V,D,I,Z,C} |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_re` |
| mem_addr | output | 16 | Bus address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | New stack pointer |
| kind_out | output | 2 | Entry kind taken |
| set_idis | output | 1 | Set the disable flag |

## Verification
The embedded properties assume three things about the inputs. `mem_rdata` is valid in the same cycle as `mem_re`, so the vector reads need no wait. `reset_req` is a single-cycle pulse. The core does not rely on `boundary` while `busy` is high. The stimulus drives every input on the falling edge. It raises `nmi_line` at least one cycle before the boundary meant to take it, so the latch has settled. It pulses `reset_req` for exactly one cycle, and it issues a boundary during a sequence only on purpose, to show that the strobe is ignored. The scoreboard records the exact cycle of every expected write and of `done`, so a shift in timing shows up as a mismatch.

// File: rtl/irq_seq_pkg.sv
// Package: shared constants and types for the interrupt entry sequencer.
// Assumes an 8-bit data bus and a 16-bit address bus.
package irq_seq_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    // Entry kind codes, also presented on kind_out.
    typedef enum logic [1:0] {
        KIND_RESET = 2'b00,
        KIND_NMI   = 2'b01,
        KIND_IRQ   = 2'b10,
        KIND_NONE  = 2'b11
    } kind_t;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_VEC_L,
        ST_VEC_H,
        ST_DONE
    } state_t;
endpackage

// File: rtl/irq_seq_request.sv
// Module: request latches and fixed-priority arbitration.
// Holds the reset and non-maskable requests. Maskable sources are levels.
// Picks a winner when 'sample' is high. Assumes reset_req is a one-cycle pulse.
module irq_seq_request
    import irq_seq_pkg::*;
#(
    parameter int IRQ_SRCS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample,
    input  logic                reset_req,
    input  logic                nmi_line,
    input  logic [IRQ_SRCS-1:0] irq_src,
    input  logic                flag_idis,
    output logic                grant_valid,
    output kind_t               grant_kind
);
    logic pend_rst;
    logic pend_nmi;
    logic nmi_prev;
    logic nmi_edge;
    logic irq_any;
    logic [IRQ_SRCS:0] irq_chain;

    // Edge detect on the non-maskable line.
    assign nmi_edge = nmi_line && !nmi_prev;

    // OR-reduce the maskable sources as a chain.
    assign irq_chain[0] = 1'b0;
    for (genvar g = 0; g < IRQ_SRCS; g++) begin : g_irq_or
        assign irq_chain[g+1] = irq_chain[g] | irq_src[g];
    end
    assign irq_any = irq_chain[IRQ_SRCS];

    // Fixed priority: reset, then non-maskable, then unmasked maskable.
    always_comb begin
        grant_kind = KIND_NONE;
        if (pend_rst)
            grant_kind = KIND_RESET;
        else if (pend_nmi)
            grant_kind = KIND_NMI;
        else if (irq_any && !flag_idis)
            grant_kind = KIND_IRQ;
        grant_valid = sample && (grant_kind != KIND_NONE);
    end

    // Request latches: a reset entry clears both; a serviced NMI clears itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_rst <= 1'b0;
            pend_nmi <= 1'b0;
            nmi_prev <= 1'b0;
        end else begin
            nmi_prev <= nmi_line;
            if (grant_valid && grant_kind == KIND_RESET) begin
                pend_rst <= 1'b0;
                pend_nmi <= 1'b0;
            end else begin
                if (reset_req)
                    pend_rst <= 1'b1;
                if (grant_valid && grant_kind == KIND_NMI)
                    pend_nmi <= 1'b0;
                if (nmi_edge)
                    pend_nmi <= 1'b1;
            end
        end
    end

    // R3: a serviced NMI is gone on the next cycle unless a fresh edge arrived.
    assert_nmi_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_kind == KIND_NMI && !nmi_edge) |=> !pend_nmi);

    // R8: a reset entry leaves no pending reset or NMI behind.
    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_kind == KIND_RESET) |=> (!pend_rst && !pend_nmi));

    // R3: a line that stays high never re-arms the latch.
    assert_held_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nmi_line) && nmi_line && !pend_nmi) |=> !pend_nmi);
endmodule

// File: rtl/irq_seq_status.sv
// Module: packs the six processor flags into the pushed status byte.
// Input order is {N,V,D,I,Z,C}. Bit 5 of the result is 1 and bit 4 is 0.
module irq_seq_status
    import irq_seq_pkg::*;
(
    input  logic [5:0]    flags,
    output logic [DW-1:0] status
);
    // Place the flags and the two fixed bits.
    always_comb begin
        status = {flags[5], flags[4], 1'b1, 1'b0,
                  flags[3], flags[2], flags[1], flags[0]};
    end

    // R5: the fixed bits never change.
    always_comb begin
        assert_fixed_bits_R5: assert (status[5] == 1'b1 && status[4] == 1'b0);
    end
endmodule

// File: rtl/irq_seq_engine.sv
// Module: entry sequencer. Runs the stack writes, the vector reads and the done pulse.
// Captures pc, sp and status when 'start' is high. Assumes mem_rdata is valid in the read cycle.
module irq_seq_engine
    import irq_seq_pkg::*;
#(
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] VEC_RESET  = 16'hFFFC,
    parameter logic [AW-1:0] VEC_NMI    = 16'hFFFA,
    parameter logic [AW-1:0] VEC_IRQ    = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  kind_t         start_kind,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic [1:0]    kind_out,
    output logic          set_idis
);
    state_t        state;
    kind_t         kind_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] sp_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] vec_lo_q;
    logic [DW-1:0] vec_hi_q;
    logic [AW-1:0] vec_base;

    // Vector base address for the captured kind.
    always_comb begin
        case (kind_q)
            KIND_RESET: vec_base = VEC_RESET;
            KIND_NMI:   vec_base = VEC_NMI;
            default:    vec_base = VEC_IRQ;
        endcase
    end

    // State advance and capture of the sequence operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind_q   <= KIND_NONE;
            pc_q     <= '0;
            sp_q     <= '0;
            stat_q   <= '0;
            vec_lo_q <= '0;
            vec_hi_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_LATCH;
                        kind_q <= start_kind;
                        pc_q   <= pc_in;
                        sp_q   <= sp_in;
                        stat_q <= status_in;
                    end
                end
                ST_LATCH:  state <= (kind_q == KIND_RESET) ? ST_VEC_L : ST_PUSH_H;
                ST_PUSH_H: begin state <= ST_PUSH_L; sp_q <= sp_q - 8'd1; end
                ST_PUSH_L: begin state <= ST_PUSH_P; sp_q <= sp_q - 8'd1; end
                ST_PUSH_P: begin state <= ST_VEC_L;  sp_q <= sp_q - 8'd1; end
                ST_VEC_L:  begin state <= ST_VEC_H;  vec_lo_q <= mem_rdata; end
                ST_VEC_H:  begin state <= ST_DONE;   vec_hi_q <= mem_rdata; end
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Bus drive for the current state.
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_H: begin mem_we = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[AW-1:DW]; end
            ST_PUSH_L: begin mem_we = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[DW-1:0]; end
            ST_PUSH_P: begin mem_we = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = stat_q; end
            ST_VEC_L:  begin mem_re = 1'b1; mem_addr = vec_base; end
            ST_VEC_H:  begin mem_re = 1'b1; mem_addr = vec_base + 16'd1; end
            default:   ;
        endcase
    end

    // Result presentation.
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        pc_out   = {vec_hi_q, vec_lo_q};
        sp_out   = sp_q;
        kind_out = kind_q;
        set_idis = done && (kind_q != KIND_RESET);
    end

    // R4: writes stay in the stack page.
    assert_stack_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    // R4: back-to-back writes move down by one.
    assert_push_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) - 8'd1));

    // R6: the high vector byte comes from the next address after the low byte.
    assert_vector_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R7: the disable flag is set only after all three pushes, in the seventh cycle.
    assert_entry_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_idis |-> ($past(mem_we, 3) && $past(mem_we, 5) && !$past(mem_we, 6)));

    // R8: a reset entry completes with no write in its last three cycles.
    assert_reset_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_out == 2'b00) |-> (!$past(mem_we, 1) && !$past(mem_we, 2) && !$past(mem_we, 3)));

    // R7: done lasts exactly one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/irq_entry_seq.sv
// Top: prioritised interrupt entry sequencer.
// Samples requests on 'boundary' while idle and hands the winner to the engine.
// Assumes the core applies pc_out, sp_out and set_idis when done is high.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              IRQ_SRCS   = 2,
    parameter logic [DW-1:0]   STACK_PAGE = 8'h01,
    parameter logic [AW-1:0]   VEC_RESET  = 16'hFFFC,
    parameter logic [AW-1:0]   VEC_NMI    = 16'hFFFA,
    parameter logic [AW-1:0]   VEC_IRQ    = 16'hFFFE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary,
    input  logic                reset_req,
    input  logic                nmi_line,
    input  logic [IRQ_SRCS-1:0] irq_src,
    input  logic [5:0]          cpu_flags,
    input  logic [15:0]         pc_in,
    input  logic [7:0]          sp_in,
    input  logic [7:0]          mem_rdata,
    output logic [15:0]         mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [7:0]          mem_wdata,
    output logic                busy,
    output logic                done,
    output logic [15:0]         pc_out,
    output logic [7:0]          sp_out,
    output logic [1:0]          kind_out,
    output logic                set_idis
);
    localparam int FLAG_IDIS = 2;

    logic          sample;
    logic          grant_valid;
    kind_t         grant_kind;
    logic [DW-1:0] status_byte;

    // Sample requests only on a boundary while idle.
    assign sample = boundary && !busy;

    irq_seq_request #(.IRQ_SRCS(IRQ_SRCS)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample      (sample),
        .reset_req   (reset_req),
        .nmi_line    (nmi_line),
        .irq_src     (irq_src),
        .flag_idis   (cpu_flags[FLAG_IDIS]),
        .grant_valid (grant_valid),
        .grant_kind  (grant_kind)
    );

    irq_seq_status u_stat (
        .flags  (cpu_flags),
        .status (status_byte)
    );

    irq_seq_engine #(
        .STACK_PAGE (STACK_PAGE),
        .VEC_RESET  (VEC_RESET),
        .VEC_NMI    (VEC_NMI),
        .VEC_IRQ    (VEC_IRQ)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (grant_valid),
        .start_kind (grant_kind),
        .pc_in      (pc_in),
        .sp_in      (sp_in),
        .status_in  (status_byte),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .done       (done),
        .pc_out     (pc_out),
        .sp_out     (sp_out),
        .kind_out   (kind_out),
        .set_idis   (set_idis)
    );

    // R2: a maskable entry never starts while the disable flag is set.
    assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy) == 1'b0 && busy == 1'b0 && grant_valid && cpu_flags[FLAG_IDIS])
            |-> (grant_kind != KIND_IRQ));

    // R9: no new sequence starts while one is running.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        reset_req = 1'b0;
    logic        nmi_line = 1'b0;
    logic [1:0]  irq_src = 2'b00;
    logic [5:0]  cpu_flags = 6'b000100;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  sp_in = 8'hFF;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic        busy, done;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic [1:0]  kind_out;
    logic        set_idis;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    typedef struct {
        bit          is_done;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [15:0] pc;
        logic [7:0]  sp;
        logic [1:0]  kind;
        bit          seti;
        int          at;
        string       req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .reset_req(reset_req),
        .nmi_line(nmi_line), .irq_src(irq_src), .cpu_flags(cpu_flags),
        .pc_in(pc_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .kind_out(kind_out), .set_idis(set_idis)
    );

    // Memory model: distinct byte for every vector address.
    function automatic logic [7:0] romv(input logic [15:0] a);
        return {a[3:0], ~a[3:0]} ^ 8'h21;
    endfunction
    always_comb mem_rdata = mem_re ? romv(mem_addr) : 8'h00;

    // Status layout per R5.
    function automatic logic [7:0] pack(input logic [5:0] f);
        return {f[5], f[4], 1'b1, 1'b0, f[3], f[2], f[1], f[0]};
    endfunction

    task automatic note(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected items as bus writes and done pulses appear.
    always @(negedge clk) begin
        if (rst_n && (mem_we || done)) begin
            if (sb.size() == 0) begin
                note(1'b0, "R9", "unexpected activity", {mem_addr, 7'b0, mem_we, 7'b0, done}, 64'h0);
            end else begin
                item_t e;
                e = sb.pop_front();
                if (!e.is_done) begin
                    note(mem_we && !done && mem_addr == e.addr && mem_wdata == e.data && cyc == e.at, e.req,
                         "stack write {addr,data,cycle}", {mem_addr, mem_wdata, 8'h0, cyc[31:0]},
                         {e.addr, e.data, 8'h0, e.at[31:0]});
                end else begin
                    note(done && pc_out == e.pc && sp_out == e.sp && kind_out == e.kind &&
                         set_idis == e.seti && cyc == e.at, e.req,
                         "done {pc,sp,kind,seti,cycle}",
                         {pc_out, sp_out, 6'b0, kind_out, 7'b0, set_idis, 8'h0, cyc[15:0]},
                         {e.pc, e.sp, 6'b0, e.kind, 7'b0, e.seti, 8'h0, e.at[15:0]});
                end
            end
        end
    end

    // Driver: pulse a boundary and push the items the requirements predict.
    task automatic entry(input logic [1:0] kind, input logic [15:0] pc, input logic [7:0] sp,
                         input logic [5:0] fl, input string req);
        item_t e;
        logic [15:0] v;
        int acc;
        @(negedge clk);
        pc_in = pc; sp_in = sp; cpu_flags = fl; boundary = 1'b1;
        acc = cyc;
        v = (kind == 2'b00) ? 16'hFFFC : (kind == 2'b01) ? 16'hFFFA : 16'hFFFE;
        if (kind != 2'b00) begin
            e = '{0, {8'h01, sp},         pc[15:8], 0, 0, 0, 0, acc + 2, {req, " R4"}}; sb.push_back(e);
            e = '{0, {8'h01, sp - 8'd1},  pc[7:0],  0, 0, 0, 0, acc + 3, {req, " R4"}}; sb.push_back(e);
            e = '{0, {8'h01, sp - 8'd2},  pack(fl), 0, 0, 0, 0, acc + 4, {req, " R5"}}; sb.push_back(e);
            e = '{1, 0, 0, {romv(v + 16'd1), romv(v)}, sp - 8'd3, kind, 1, acc + 7, {req, " R6 R7 R10"}};
            sb.push_back(e);
        end else begin
            e = '{1, 0, 0, {romv(v + 16'd1), romv(v)}, sp, kind, 0, acc + 4, {req, " R6 R8"}};
            sb.push_back(e);
        end
        @(negedge clk);
        boundary = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            if (sb.size() == 0 && !busy) break;
            @(negedge clk);
        end
        if (sb.size() != 0) note(1'b0, "R7", "missing items", sb.size(), 0);
        sb.delete();
    endtask

    // Pulse a boundary and expect nothing to happen.
    task automatic quiet(input logic [5:0] fl, input string req);
        bit ok = 1'b1;
        @(negedge clk);
        cpu_flags = fl; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (busy || mem_we || mem_re || done) ok = 1'b0;
            @(negedge clk);
        end
        note(ok, req, "idle after boundary", {busy, mem_we, mem_re, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        note(!busy && !done && !mem_we && !mem_re, "R9", "reset state", {busy, done, mem_we, mem_re}, 0);

        // R9: boundary with nothing pending.
        quiet(6'b000000, "R9");
        // R2: both sources high but masked.
        irq_src = 2'b11;
        quiet(6'b000100, "R2");

        // R2: source 0, disable flag clear, plus a boundary mid-sequence (R9).
        irq_src = 2'b01;
        entry(2'b10, 16'hC123, 8'hFF, 6'b101010, "R2");
        repeat (2) @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        wait_idle();
        irq_src = 2'b00;
        quiet(6'b000000, "R9");

        // R4: source 1 with stack pointer wrap, flags pattern for R5.
        irq_src = 2'b10;
        entry(2'b10, 16'h8001, 8'h01, 6'b111011, "R4");
        wait_idle();
        entry(2'b10, 16'h00FE, 8'h80, 6'b000000, "R5");
        wait_idle();
        irq_src = 2'b00;

        // R3: NMI taken even with disable flag set; held line does not retrigger.
        nmi_line = 1'b1;
        @(negedge clk);
        entry(2'b01, 16'h1234, 8'hF0, 6'b111111, "R3");
        wait_idle();
        quiet(6'b111111, "R3");
        nmi_line = 1'b0;
        @(negedge clk);
        nmi_line = 1'b1;
        @(negedge clk);
        entry(2'b01, 16'hABCD, 8'h10, 6'b000100, "R3");
        wait_idle();

        // R1: NMI wins over unmasked IRQ; the IRQ follows at the next boundary.
        nmi_line = 1'b0;
        @(negedge clk);
        nmi_line = 1'b1;
        irq_src = 2'b01;
        @(negedge clk);
        entry(2'b01, 16'h4000, 8'hC0, 6'b000000, "R1");
        wait_idle();
        entry(2'b10, 16'h4100, 8'hBD, 6'b000000, "R1");
        wait_idle();
        irq_src = 2'b00;

        // R1 and R8: reset wins over pending NMI and IRQ, and discards the NMI.
        nmi_line = 1'b0;
        @(negedge clk);
        nmi_line = 1'b1;
        reset_req = 1'b1;
        @(negedge clk);
        reset_req = 1'b0;
        irq_src = 2'b11;
        entry(2'b00, 16'h5555, 8'h33, 6'b000000, "R1");
        wait_idle();
        irq_src = 2'b00;
        quiet(6'b000000, "R8");
        nmi_line = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog.
    initial begin
        #2000000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule